// File: doc/BRIEF.md
# Transmit Frame Padder and FCS Appender

This block sits in the transmit path of an Ethernet MAC, between the transmit FIFO and the byte-to-nibble serializer. The serializer asks for one byte at a time with a request strobe. The block answers each request in the same cycle with a frame byte, a zero pad byte or one of the four FCS bytes. Frames enter as a byte stream marked with start and end flags. Two control bits are sampled with the first byte of each frame: one enables padding and the other enables FCS appending.

Short frames are padded with zeros to the minimum length when padding is enabled. A padded frame always gets an FCS, even if FCS appending is off. The CRC covers every byte that goes out before it, pad bytes included. If the serializer requests a byte in mid-frame and the FIFO has none, the block treats this as an underrun. It stops taking data and sends a deliberately corrupted FCS, so the receiver drops the frame. A byte that the FIFO offers one cycle late does not hide the underrun. After each frame the block reports a status word for one cycle.

Top module: `tx_pad_fcs`

## Requirements
- R1: Each frame byte taken from the input is sent on `tx_data` in the same cycle, in order. `tx_last` is high only on the final byte sent for the frame.
- R2: With pad enable set, a frame whose data is shorter than MIN_LEN (60) bytes is followed by 0x00 bytes until MIN_LEN bytes have been sent. The FCS comes after the pad bytes.
- R3: A padded frame always ends with a valid FCS, whatever the value of the FCS-enable bit.
- R4: With FCS enable set, four FCS bytes follow the data (or the pad). The FCS is the complement of CRC-32 (polynomial 0x04C11DB7, register preset to all ones, bits of each byte taken LSB first), and it is sent least significant byte first.
- R5: When no padding applies and FCS enable is clear, the frame leaves unchanged and `tx_last` marks its last data byte.
- R6: The FCS covers every byte sent before it, pad bytes included.
- R7: An underrun is a request in mid-frame while `in_valid` is low. In that same slot the block sends the first of four bytes that are the bitwise complement of the correct FCS over the bytes already sent. It takes no input until the frame is over and it does not pad.
- R8: One cycle after the cycle with `tx_last`, `st_valid` is high for exactly one cycle. With it come the total byte count (data, pad and FCS), a flag for padding, a flag for an appended FCS and a flag for underrun.
- R9: The pad-enable and FCS-enable bits act only in the cycle that takes a frame's first byte. Changes to them later in the frame have no effect.
- R10: After reset, no byte is sent and no status is raised. While idle, input bytes that lack the start flag are taken and thrown away without being sent.
- R11: `tx_valid` is never high in a cycle without `tx_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | FIFO has a byte on `in_data` |
| in_data | input | 8 | Frame byte from the FIFO |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Byte on `in_data` is taken at this edge |
| pad_en | input | 1 | Pad short frames (sampled with the first byte) |
| fcs_en | input | 1 | Append FCS (sampled with the first byte) |
| tx_req | input | 1 | Serializer wants a byte this cycle |
| tx_valid | output | 1 | `tx_data` carries a frame byte |
| tx_data | output | 8 | Byte to the serializer |
| tx_last | output | 1 | Final byte of the frame |
| st_valid | output | 1 | Status word valid (one cycle) |
| st_bytes | output | LEN_W | Bytes sent for the frame, FCS included |
| st_pad | output | 1 | Padding was applied |
| st_fcs | output | 1 | An FCS was appended |
| st_undr | output | 1 | Frame ended by underrun |

## Verification
The hardest case to reach is an underrun that the FIFO refills one cycle later. The serializer request must land exactly when `in_valid` is low, in the middle of a frame, and the next byte must then appear at once. The stimulus withholds the byte only in a cycle where it has already chosen to raise the request, and offers the byte again in the following cycle. Both directed frames and random frames with a random underrun position go through this. The bench then checks that the stray bytes are dropped while idle and that the corrupted FCS matches the bytes actually sent.

// File: rtl/tx_pad_fcs.sv
module tx_pad_fcs #(
  parameter int MIN_LEN = 60,
  parameter int LEN_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  output logic             in_ready,
  input  logic             pad_en,
  input  logic             fcs_en,
  input  logic             tx_req,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  output logic             st_valid,
  output logic [LEN_W-1:0] st_bytes,
  output logic             st_pad,
  output logic             st_fcs,
  output logic             st_undr
);

  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_PAD, S_FCS} state_t;

  state_t           st;
  logic [31:0]      crc;
  logic [LEN_W-1:0] len;
  logic [1:0]       idx;
  logic             pad_q, fcs_q, bad_q, padded_q;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  logic idle, in_frame, sof_take, dat_take, take, undr;
  logic pad_c, fcs_c, go_pad, go_fcs, end_plain;
  logic pad_out, fcs_out, fcs_done;
  logic [LEN_W-1:0] len_n;
  logic [31:0] fcs_word;

  assign idle      = (st == S_IDLE);
  assign in_frame  = (st == S_DATA);
  assign sof_take  = idle & in_valid & in_sof & tx_req;
  assign dat_take  = in_frame & in_valid & tx_req;
  assign take      = sof_take | dat_take;
  assign undr      = in_frame & tx_req & ~in_valid;

  assign pad_c     = idle ? pad_en : pad_q;
  assign fcs_c     = idle ? fcs_en : fcs_q;
  assign len_n     = (idle ? '0 : len) + 1'b1;

  assign go_pad    = take & in_eof & pad_c & (len_n < MIN_L);
  assign go_fcs    = take & in_eof & ~go_pad & fcs_c;
  assign end_plain = take & in_eof & ~go_pad & ~fcs_c;

  assign pad_out   = (st == S_PAD) & tx_req;
  assign fcs_out   = (st == S_FCS) & tx_req;
  assign fcs_done  = fcs_out & (idx == 2'd3);

  assign fcs_word  = (undr | bad_q) ? crc : ~crc;

  assign in_ready  = idle ? (~in_sof | tx_req) : (in_frame & tx_req);
  assign tx_valid  = take | undr | pad_out | fcs_out;
  assign tx_data   = take    ? in_data :
                     pad_out ? 8'h00   :
                     fcs_word[{idx, 3'b000} +: 8];
  assign tx_last   = end_plain | fcs_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      crc      <= '1;
      len      <= '0;
      idx      <= '0;
      pad_q    <= 1'b0;
      fcs_q    <= 1'b0;
      bad_q    <= 1'b0;
      padded_q <= 1'b0;
      st_valid <= 1'b0;
      st_bytes <= '0;
      st_pad   <= 1'b0;
      st_fcs   <= 1'b0;
      st_undr  <= 1'b0;
    end else begin
      st_valid <= 1'b0;
      if (tx_valid) len <= len_n;
      if (sof_take) begin
        pad_q    <= pad_en;
        fcs_q    <= fcs_en;
        bad_q    <= 1'b0;
        padded_q <= 1'b0;
      end
      if (take | pad_out)
        crc <= crc_byte(sof_take ? 32'hFFFF_FFFF : crc, tx_data);
      if (take)
        st <= end_plain ? S_IDLE : go_pad ? S_PAD : go_fcs ? S_FCS : S_DATA;
      if (go_pad) padded_q <= 1'b1;
      if (undr) begin
        st    <= S_FCS;
        idx   <= 2'd1;
        bad_q <= 1'b1;
      end
      if (pad_out && len_n == MIN_L) st <= S_FCS;
      if (fcs_out) begin
        idx <= idx + 2'd1;
        if (idx == 2'd3) st <= S_IDLE;
      end
      if (tx_last) begin
        st_valid <= 1'b1;
        st_bytes <= len_n;
        st_pad   <= fcs_done & padded_q;
        st_fcs   <= fcs_done;
        st_undr  <= fcs_done & bad_q;
      end
    end
  end

endmodule

// File: rtl/tx_pad_fcs_chk.sv
module tx_pad_fcs_chk #(
  parameter int MIN_LEN = 60,
  parameter int LEN_W   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_req,
  input logic             tx_valid,
  input logic             tx_last,
  input logic             st_valid,
  input logic [LEN_W-1:0] st_bytes,
  input logic             st_pad,
  input logic             st_fcs,
  input logic             st_undr
);

  p_valid_needs_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_req);

  p_last_is_sent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  p_status_follows_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |=> st_valid);

  p_status_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> $past(tx_last));

  p_pad_forces_fcs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_pad) |-> st_fcs);

  p_pad_length_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_pad) |-> (st_bytes == LEN_W'(MIN_LEN + 4)));

  p_undr_no_pad_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_undr) |-> (st_fcs && !st_pad));

endmodule

bind tx_pad_fcs tx_pad_fcs_chk #(.MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_valid(tx_valid), .tx_last(tx_last),
  .st_valid(st_valid), .st_bytes(st_bytes), .st_pad(st_pad), .st_fcs(st_fcs), .st_undr(st_undr)
);

// File: tb/tx_pad_fcs_test.sv
module tx_pad_fcs_test;
  localparam int CLK_P   = 10;
  localparam int MIN_LEN = 60;
  localparam int LEN_W   = 16;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sof = 0, in_eof = 0, pad_en = 0, fcs_en = 0, tx_req = 0;
  logic [7:0] in_data = 0;
  logic in_ready, tx_valid, tx_last, st_valid, st_pad, st_fcs, st_undr;
  logic [7:0] tx_data;
  logic [LEN_W-1:0] st_bytes;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  tx_pad_fcs #(.MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) uut (.*);

  function automatic logic [31:0] ref_fcs(input logic [7:0] q[$]);
    logic [31:0] c, r;
    logic fb;
    c = 32'hFFFF_FFFF;
    foreach (q[i])
      for (int b = 0; b < 8; b++) begin
        fb = c[31] ^ q[i][b];
        c = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C11DB7;
      end
    for (int k = 0; k < 32; k++) r[k] = c[31-k];
    return ~r;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic v, input logic [7:0] d, input logic s,
                      input logic e, input logic p, input logic f);
    @(negedge clk);
    tx_req = r; in_valid = v; in_data = d; in_sof = s; in_eof = e; pad_en = p; fcs_en = f;
    #1;
  endtask

  task automatic run_frame(input int n, input bit pe, input bit fe, input int uat,
                           input int junk, input string tag);
    logic [7:0] d[$], exp[$], got[$];
    logic [31:0] fcs;
    int idx = 0, last_pos = -1, guard = 0, viol = 0, junk_bad = 0;
    bit und = 0, st_seen = 0, padded;
    logic [LEN_W-1:0] sb = 0;
    bit sp = 0, sf = 0, su = 0;
    logic r, v;

    for (int j = 0; j < junk; j++) begin
      step($urandom_range(0, 1), 1'b1, 8'($urandom), 1'b0, 1'b0, 1'b0, 1'b0);
      if (tx_valid || !in_ready) junk_bad++;
    end
    if (junk > 0) check(junk_bad == 0, "R10 idle junk dropped", junk_bad, 0);

    for (int i = 0; i < n; i++) d.push_back(8'($urandom));

    while (!(st_seen && idx >= n) && guard < 4000) begin
      guard++;
      r = ($urandom % 4) != 0;
      v = 1'b0;
      if (idx < n) begin
        if (!und && uat > 0 && idx == uat && r) begin
          v = 1'b0; und = 1;
        end else if (!r && ($urandom % 3) == 0) v = 1'b0;
        else v = 1'b1;
      end
      step(r, v, (idx < n) ? d[idx] : 8'h00, idx == 0, idx == n - 1,
           (idx == 0) ? pe : 1'($urandom), (idx == 0) ? fe : 1'($urandom));
      if (tx_valid && !r) viol++;
      if (tx_valid) begin
        got.push_back(tx_data);
        if (tx_last) last_pos = got.size() - 1;
      end
      if (st_valid) begin
        st_seen = 1; sb = st_bytes; sp = st_pad; sf = st_fcs; su = st_undr;
      end
      if (v && in_ready) idx++;
    end
    check(guard < 4000, {tag, " frame completes"}, guard, 0);

    padded = 0;
    if (und) begin
      for (int i = 0; i < uat; i++) exp.push_back(d[i]);
      fcs = ~ref_fcs(exp);
    end else begin
      exp = d;
      if (pe && n < MIN_LEN) begin
        padded = 1;
        while (exp.size() < MIN_LEN) exp.push_back(8'h00);
      end
      fcs = ref_fcs(exp);
    end
    if (und || padded || fe)
      for (int k = 0; k < 4; k++) exp.push_back(fcs[8*k +: 8]);

    begin
      int bad_at = -1;
      if (got.size() == exp.size())
        foreach (exp[i]) if (bad_at < 0 && got[i] != exp[i]) bad_at = i;
      check(got.size() == exp.size(), {tag, " byte count on line"}, got.size(), exp.size());
      if (got.size() == exp.size())
        check(bad_at < 0, {tag, " byte contents"},
              (bad_at < 0) ? 0 : got[bad_at], (bad_at < 0) ? 0 : exp[bad_at]);
    end
    check(last_pos == exp.size() - 1, "R1 tx_last position", last_pos, exp.size() - 1);
    check(viol == 0, "R11 no byte without request", viol, 0);
    check(sb == LEN_W'(exp.size()), "R8 status count", sb, exp.size());
    check({sp, sf, su} == {padded, und || padded || fe, und}, "R8 status flags",
          {sp, sf, su}, {padded, und || padded || fe, und});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    step(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    check(tx_valid == 0, "R10 reset no byte", tx_valid, 0);
    check(st_valid == 0, "R10 reset no status", st_valid, 0);

    run_frame(59, 1, 0, 0, 0, "R2 R3 R6 pad 59");
    run_frame(60, 1, 0, 0, 0, "R5 no pad at 60");
    run_frame(1, 1, 1, 0, 3, "R2 single byte padded");
    run_frame(64, 0, 1, 0, 0, "R4 fcs only");
    run_frame(20, 0, 0, 0, 0, "R5 short no pad no fcs");
    run_frame(30, 1, 1, 5, 0, "R7 underrun refill");
    run_frame(70, 0, 0, 65, 0, "R7 underrun long");
    run_frame(10, 1, 0, 0, 2, "R9 controls toggled later");
    run_frame(2, 0, 1, 1, 0, "R7 underrun second byte");

    for (int i = 0; i < 120; i++) begin
      int n, u;
      bit pe, fe;
      n  = $urandom_range(1, 90);
      pe = 1'($urandom);
      fe = 1'($urandom);
      u  = (n > 1 && ($urandom % 4) == 0) ? $urandom_range(1, n - 1) : 0;
      run_frame(n, pe, fe, u, $urandom_range(0, 2),
                u > 0 ? "R7 random" : (pe && n < MIN_LEN) ? "R6 random" : fe ? "R4 random" : "R5 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule